// File: doc/BRIEF.md
# Energy Pulse Source Selector

This block decides which real-energy and reactive-energy values feed the downstream pulse generators at the end of each accumulation interval. A small configuration register chooses between two sources. In controller mode the block passes through a pair of values that the controller has written. In derived mode it builds the values from the per-element watt and var sums of two metering elements.

Derived mode has two equations. In single-element mode the block takes the element whose current-squared sum is larger. In two-element mode it adds both elements with saturation. Before either equation runs, an element whose current channel is set to shunt mode has its watt and var sums multiplied by eight, and the product saturates at the output width.

A three-state machine sequences the work. In `ST_IDLE` the block waits for the accumulation-done strobe. On that strobe it snapshots the inputs and the configuration and moves to `ST_SCALE`, where it registers the shunt-scaled sums. It then moves unconditionally to `ST_COMMIT`, where it registers the selected outputs, and returns unconditionally to `ST_IDLE`.

Top module: `energy_pulse_sel`

## Requirements
- R1: The configuration register resets to 0x5020 and is visible on `cfg_q`. A cycle with `cfg_we` high loads `cfg_wdata` into it at that clock edge, and it holds its value otherwise. Fields: bit 0 is shunt mode for element 0, bit 1 is shunt mode for element 1, bit 2 is the controller-source bit, and bits 5:3 are the equation mode. The other bits are stored and have no effect.
- R2: After reset, `pulse_w` and `pulse_var` are zero.
- R3: When `acc_done` is sampled high in `ST_IDLE`, the outputs take their new values at the third rising edge counting that one. They hold at all other times. A strobe sampled during `ST_SCALE` or `ST_COMMIT` is ignored.
- R4: The sums, the controller values and the configuration are taken only at the strobe edge. Later input changes do not affect that interval's result.
- R5: When the controller-source bit is 1, `pulse_w` equals `ctl_w` and `pulse_var` equals `ctl_var` exactly, with no shunt gain.
- R6: When the controller-source bit is 0 and the mode is 2, `pulse_w` = scaled W0 + scaled W1 and `pulse_var` = scaled VAR0 + scaled VAR1, each clamped to the signed OUT_W range instead of wrapping.
- R7: When the controller-source bit is 0 and the mode is 0, the outputs are element 1's scaled sums if `i1sq` > `i0sq`. Otherwise they are element 0's scaled sums, so a tie selects element 0.
- R8: Mode values other than 0 and 2 behave exactly like mode 0.
- R9: For an element in shunt mode, its watt and var sums are multiplied by 8 and clamped to the signed OUT_W range before selection or addition. Without shunt mode they are sign-extended unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_q | output | 16 | Current configuration register |
| acc_done | input | 1 | End-of-accumulation strobe |
| w0_sum | input | SUM_W | Element 0 watt sum, signed |
| var0_sum | input | SUM_W | Element 0 var sum, signed |
| i0sq_sum | input | SUM_W | Element 0 current-squared sum, unsigned |
| w1_sum | input | SUM_W | Element 1 watt sum, signed |
| var1_sum | input | SUM_W | Element 1 var sum, signed |
| i1sq_sum | input | SUM_W | Element 1 current-squared sum, unsigned |
| ctl_w | input | OUT_W | Controller real-energy value, signed |
| ctl_var | input | OUT_W | Controller reactive-energy value, signed |
| pulse_w | output | OUT_W | Selected real-energy pulse input, signed |
| pulse_var | output | OUT_W | Selected reactive-energy pulse input, signed |

## Verification
The bench builds the block with SUM_W = 12 and OUT_W = 14. With these values, multiplying a full-scale sum by eight overruns the output range, and so does adding two large scaled sums. Both clamps, positive and negative, are therefore reached by the random stimulus as well as by directed cases. Because the output is two bits wider than the sums, it also checks that unscaled values are sign-extended and not truncated. Directed cases cover equal current-squared sums, every mode value, and strobes that arrive while the block is busy.

// File: rtl/epsel_pkg.sv
package epsel_pkg;

    localparam int CFG_W = 16;
    localparam logic [CFG_W-1:0] CFG_RESET = 16'h5020;

    // configuration field positions
    localparam int SHUNT0_BIT = 0;
    localparam int SHUNT1_BIT = 1;
    localparam int CTLSRC_BIT = 2;
    localparam int MODE_LO    = 3;
    localparam int MODE_W     = 3;

    localparam logic [MODE_W-1:0] MODE_PAIR = 3'd2;

    // number of quantities scaled per interval (w0, var0, w1, var1)
    localparam int NQ = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCALE  = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/epsel_gain.sv
module epsel_gain #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 32
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic                    shunt,
    output logic signed [OUT_W-1:0] dout
);
    localparam int BASE_W = (IN_W + 3 > OUT_W) ? IN_W + 3 : OUT_W;
    localparam int EW     = BASE_W + 1;

    localparam logic signed [EW-1:0] MAXV = {{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EW-1:0] MINV = {{(EW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [EW-1:0] wide;
    logic signed [EW-1:0] shifted;

    always_comb begin
        wide    = {{(EW-IN_W){din[IN_W-1]}}, din};
        shifted = shunt ? (wide <<< 3) : wide;
        if (shifted > MAXV) begin
            dout = MAXV[OUT_W-1:0];
        end else if (shifted < MINV) begin
            dout = MINV[OUT_W-1:0];
        end else begin
            dout = shifted[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/epsel_satadd.sv
module epsel_satadd #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] s
);
    logic signed [W:0] full;

    always_comb begin
        full = {a[W-1], a} + {b[W-1], b};
        if (full[W] != full[W-1]) begin
            s = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            s = full[W-1:0];
        end
    end
endmodule

// File: rtl/epsel_route.sv
module epsel_route #(
    parameter int SUM_W = 32,
    parameter int OUT_W = 32
) (
    input  logic                     ctl_src,
    input  logic [2:0]               mode,
    input  logic signed [OUT_W-1:0]  sw0,
    input  logic signed [OUT_W-1:0]  svar0,
    input  logic signed [OUT_W-1:0]  sw1,
    input  logic signed [OUT_W-1:0]  svar1,
    input  logic [SUM_W-1:0]         isq0,
    input  logic [SUM_W-1:0]         isq1,
    input  logic signed [OUT_W-1:0]  cw,
    input  logic signed [OUT_W-1:0]  cvar,
    output logic signed [OUT_W-1:0]  nxt_w,
    output logic signed [OUT_W-1:0]  nxt_var
);
    import epsel_pkg::*;

    logic signed [OUT_W-1:0] pair_w;
    logic signed [OUT_W-1:0] pair_var;
    logic                    pick_one;

    epsel_satadd #(.W(OUT_W)) u_add_w (
        .a(sw0), .b(sw1), .s(pair_w)
    );

    epsel_satadd #(.W(OUT_W)) u_add_var (
        .a(svar0), .b(svar1), .s(pair_var)
    );

    always_comb begin
        pick_one = (isq1 > isq0);
        if (ctl_src) begin
            nxt_w   = cw;
            nxt_var = cvar;
        end else if (mode == MODE_PAIR) begin
            nxt_w   = pair_w;
            nxt_var = pair_var;
        end else if (pick_one) begin
            nxt_w   = sw1;
            nxt_var = svar1;
        end else begin
            nxt_w   = sw0;
            nxt_var = svar0;
        end
    end
endmodule

// File: rtl/energy_pulse_sel.sv
module energy_pulse_sel #(
    parameter int SUM_W = 32,
    parameter int OUT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [15:0]              cfg_wdata,
    output logic [15:0]              cfg_q,
    input  logic                     acc_done,
    input  logic signed [SUM_W-1:0]  w0_sum,
    input  logic signed [SUM_W-1:0]  var0_sum,
    input  logic [SUM_W-1:0]         i0sq_sum,
    input  logic signed [SUM_W-1:0]  w1_sum,
    input  logic signed [SUM_W-1:0]  var1_sum,
    input  logic [SUM_W-1:0]         i1sq_sum,
    input  logic signed [OUT_W-1:0]  ctl_w,
    input  logic signed [OUT_W-1:0]  ctl_var,
    output logic signed [OUT_W-1:0]  pulse_w,
    output logic signed [OUT_W-1:0]  pulse_var
);
    import epsel_pkg::*;

    seq_state_e state, state_nxt;

    logic [CFG_W-1:0] cfg_reg;

    // snapshot taken at the strobe
    logic signed [SUM_W-1:0] raw_q [NQ];
    logic [SUM_W-1:0]        isq0_q, isq1_q;
    logic signed [OUT_W-1:0] snap_ctl_w, snap_ctl_var;
    logic                    snap_sh0, snap_sh1, snap_ctl;
    logic [MODE_W-1:0]       snap_mode;

    // scaled sums
    logic signed [OUT_W-1:0] gain_d  [NQ];
    logic signed [OUT_W-1:0] scaled_q [NQ];

    logic signed [OUT_W-1:0] nxt_w, nxt_var;
    logic                    take;

    assign cfg_q = cfg_reg;
    assign take  = (state == ST_IDLE) && acc_done;

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_reg <= CFG_RESET;
        end else if (cfg_we) begin
            cfg_reg <= cfg_wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   state_nxt = acc_done ? ST_SCALE : ST_IDLE;
            ST_SCALE:  state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // snapshot capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NQ; k++) raw_q[k] <= '0;
            isq0_q       <= '0;
            isq1_q       <= '0;
            snap_ctl_w   <= '0;
            snap_ctl_var <= '0;
            snap_sh0     <= 1'b0;
            snap_sh1     <= 1'b0;
            snap_ctl     <= 1'b0;
            snap_mode    <= '0;
        end else if (take) begin
            raw_q[0]     <= w0_sum;
            raw_q[1]     <= var0_sum;
            raw_q[2]     <= w1_sum;
            raw_q[3]     <= var1_sum;
            isq0_q       <= i0sq_sum;
            isq1_q       <= i1sq_sum;
            snap_ctl_w   <= ctl_w;
            snap_ctl_var <= ctl_var;
            snap_sh0     <= cfg_reg[SHUNT0_BIT];
            snap_sh1     <= cfg_reg[SHUNT1_BIT];
            snap_ctl     <= cfg_reg[CTLSRC_BIT];
            snap_mode    <= cfg_reg[MODE_LO +: MODE_W];
        end
    end

    // shunt gain, one stage per quantity; elements own quantities in pairs
    for (genvar g = 0; g < NQ; g++) begin : g_gain
        epsel_gain #(.IN_W(SUM_W), .OUT_W(OUT_W)) u_gain (
            .din   (raw_q[g]),
            .shunt ((g < 2) ? snap_sh0 : snap_sh1),
            .dout  (gain_d[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scaled_q[g] <= '0;
            end else if (state == ST_SCALE) begin
                scaled_q[g] <= gain_d[g];
            end
        end
    end

    epsel_route #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_route (
        .ctl_src (snap_ctl),
        .mode    (snap_mode),
        .sw0     (scaled_q[0]),
        .svar0   (scaled_q[1]),
        .sw1     (scaled_q[2]),
        .svar1   (scaled_q[3]),
        .isq0    (isq0_q),
        .isq1    (isq1_q),
        .cw      (snap_ctl_w),
        .cvar    (snap_ctl_var),
        .nxt_w   (nxt_w),
        .nxt_var (nxt_var)
    );

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_w   <= '0;
            pulse_var <= '0;
        end else if (state == ST_COMMIT) begin
            pulse_w   <= nxt_w;
            pulse_var <= nxt_var;
        end
    end
endmodule

// File: rtl/epsel_checker.sv
module epsel_checker #(
    parameter int OUT_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic [15:0]             cfg_q,
    input logic [1:0]              st,
    input logic                    snap_ctl,
    input logic [2:0]              snap_mode,
    input logic signed [OUT_W-1:0] snap_ctl_w,
    input logic signed [OUT_W-1:0] snap_ctl_var,
    input logic signed [OUT_W-1:0] sw0,
    input logic signed [OUT_W-1:0] sw1,
    input logic signed [OUT_W-1:0] pulse_w,
    input logic signed [OUT_W-1:0] pulse_var
);
    localparam logic [1:0] S_IDLE   = 2'd0;
    localparam logic [1:0] S_SCALE  = 2'd1;
    localparam logic [1:0] S_COMMIT = 2'd2;

    a_r1_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

    a_r3_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_COMMIT) |=> ($stable(pulse_w) && $stable(pulse_var)));

    a_r3_scale_to_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SCALE) |=> (st == S_COMMIT));

    a_r3_commit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_COMMIT) |=> (st == S_IDLE));

    a_r5_ctl_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_COMMIT && snap_ctl) |=>
            (pulse_w == $past(snap_ctl_w) && pulse_var == $past(snap_ctl_var)));

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_COMMIT && !snap_ctl && snap_mode == 3'd2 &&
         !sw0[OUT_W-1] && !sw1[OUT_W-1]) |=> !pulse_w[OUT_W-1]);
endmodule

bind energy_pulse_sel epsel_checker #(.OUT_W(OUT_W)) u_epsel_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_q        (cfg_q),
    .st           (state),
    .snap_ctl     (snap_ctl),
    .snap_mode    (snap_mode),
    .snap_ctl_w   (snap_ctl_w),
    .snap_ctl_var (snap_ctl_var),
    .sw0          (scaled_q[0]),
    .sw1          (scaled_q[2]),
    .pulse_w      (pulse_w),
    .pulse_var    (pulse_var)
);

// File: tb/energy_pulse_sel_bench.sv
`timescale 1ns/1ps
module energy_pulse_sel_bench;
    localparam int SUM_W = 12;
    localparam int OUT_W = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic acc_done = 1'b0;
    logic signed [SUM_W-1:0] w0 = '0, var0 = '0, w1 = '0, var1 = '0;
    logic [SUM_W-1:0] i0 = '0, i1 = '0;
    logic signed [OUT_W-1:0] cw = '0, cv = '0;
    logic signed [OUT_W-1:0] pw, pv;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit summary_done = 0;
    logic [15:0] cur_cfg = 16'h5020;
    longint prev_w = 0, prev_v = 0;

    always #10 clk = ~clk;

    energy_pulse_sel #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_energy_pulse_sel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .acc_done(acc_done),
        .w0_sum(w0), .var0_sum(var0), .i0sq_sum(i0),
        .w1_sum(w1), .var1_sum(var1), .i1sq_sum(i1),
        .ctl_w(cw), .ctl_var(cv), .pulse_w(pw), .pulse_var(pv)
    );

    function automatic longint clampv(longint v);
        longint mx = (longint'(1) <<< (OUT_W-1)) - 1;
        longint mn = -(longint'(1) <<< (OUT_W-1));
        if (v > mx) return mx;
        if (v < mn) return mn;
        return v;
    endfunction

    function automatic longint gainv(longint v, bit sh);
        return clampv(sh ? v * 8 : v);
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    endtask

    task automatic write_cfg(logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = 16'hFFFF;
        cur_cfg = d;
        check("R1 cfg write", longint'(cfg_q), longint'(d));
    endtask

    task automatic scramble();
        w0 = SUM_W'($urandom); var0 = SUM_W'($urandom);
        w1 = SUM_W'($urandom); var1 = SUM_W'($urandom);
        i0 = SUM_W'($urandom); i1 = SUM_W'($urandom);
        cw = OUT_W'($urandom); cv = OUT_W'($urandom);
    endtask

    // one interval; inputs already driven; poke = strobe while busy
    task automatic run_interval(string req, bit poke);
        longint ew, ev;
        longint g0w, g0v, g1w, g1v;
        bit ext = cur_cfg[2];
        logic [2:0] md = cur_cfg[5:3];
        g0w = gainv(longint'(w0), cur_cfg[0]);
        g0v = gainv(longint'(var0), cur_cfg[0]);
        g1w = gainv(longint'(w1), cur_cfg[1]);
        g1v = gainv(longint'(var1), cur_cfg[1]);
        if (ext) begin
            ew = longint'(cw); ev = longint'(cv);
        end else if (md == 3'd2) begin
            ew = clampv(g0w + g1w); ev = clampv(g0v + g1v);
        end else if (i1 > i0) begin
            ew = g1w; ev = g1v;
        end else begin
            ew = g0w; ev = g0v;
        end
        acc_done = 1'b1;
        @(negedge clk);             // strobe taken
        acc_done = poke;            // R3: strobe while busy
        scramble();                 // R4: late input changes
        @(negedge clk);
        acc_done = 1'b0;
        check("R3 hold before commit w", longint'(pw), prev_w);
        check("R3 hold before commit var", longint'(pv), prev_v);
        @(negedge clk);
        check({req, " w"}, longint'(pw), ew);
        check({req, " var"}, longint'(pv), ev);
        prev_w = ew; prev_v = ev;
        if (poke) begin
            repeat (4) @(negedge clk);
            check("R3 busy strobe ignored w", longint'(pw), prev_w);
            check("R3 busy strobe ignored var", longint'(pv), prev_v);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                summary();
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset cfg", longint'(cfg_q), 64'h5020);
        check("R2 reset w", longint'(pw), 0);
        check("R2 reset var", longint'(pv), 0);

        // R8: reset config is mode 4, no shunt, derived source
        w0 = 12'sd100; var0 = -12'sd50; w1 = 12'sd7; var1 = 12'sd9;
        i0 = 12'd10; i1 = 12'd900;
        run_interval("R8 mode4 picks larger", 0);

        // R7 tie -> element 0
        write_cfg({10'h0, 3'd0, 1'b0, 1'b0, 1'b0});
        w0 = -12'sd300; var0 = 12'sd20; w1 = 12'sd55; var1 = 12'sd66;
        i0 = 12'd500; i1 = 12'd500;
        run_interval("R7 tie element0", 0);
        i0 = 12'd499; i1 = 12'd500;
        run_interval("R7 element1 larger", 0);

        // R6 saturation both directions
        write_cfg({10'h0, 3'd2, 1'b0, 1'b1, 1'b1});
        w0 = 12'sd2047; w1 = 12'sd2000; var0 = -12'sd2048; var1 = -12'sd1500;
        run_interval("R6 pair saturates", 0);
        write_cfg({10'h0, 3'd2, 1'b0, 1'b0, 1'b0});
        w0 = 12'sd2047; w1 = 12'sd2047; var0 = -12'sd2048; var1 = -12'sd2048;
        run_interval("R6 pair no shunt", 0);

        // R9 shunt gain and clamp per element
        write_cfg({10'h0, 3'd0, 1'b0, 1'b0, 1'b1});
        w0 = 12'sd1500; var0 = -12'sd1500; i0 = 12'd4000; i1 = 12'd1;
        run_interval("R9 shunt clamp", 0);
        w0 = -12'sd100; var0 = 12'sd123;
        run_interval("R9 shunt x8", 0);

        // R5 controller source ignores shunt
        write_cfg({10'h0, 3'd2, 1'b1, 1'b1, 1'b1});
        cw = -14'sd8192; cv = 14'sd8191;
        run_interval("R5 controller values", 1);

        // R8 remaining odd modes
        for (int m = 1; m < 8; m++) begin
            if (m == 2) continue;
            write_cfg({10'h0, 3'(m), 1'b0, 1'b0, 1'b0});
            scramble();
            run_interval("R8 other mode", 0);
        end

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [15:0] c;
            c = 16'($urandom);
            if ($urandom_range(0, 3) == 0) c[5:3] = 3'd2;
            write_cfg(c);
            scramble();
            if ($urandom_range(0, 7) == 0) i1 = i0;
            run_interval("R4 R6 R7 R9 random", ($urandom_range(0, 9) == 0));
        end

        summary();
    end
endmodule